// File: doc/BRIEF.md
# Flash Status Pin Controller

This block produces the drive for the open-drain status pin of a flash memory. It takes the state of the program/erase controller and turns it into a pull-down enable. The output is active low: `pin_pd_n` = 0 pulls the pin low and `pin_pd_n` = 1 releases it to high impedance. The block never drives the pin high. An external pull-up supplies the high level, so the status pins of several devices can share one wire.

The block has two kinds of behaviour:
- **Level mode** is the default after reset. The pin is held low while an operation runs. It is released when the controller is idle or suspended.
- **Pulse modes** are selected by a configure strobe with a 2-bit code. The pin gives a low pulse of `PULSE_LEN` clock cycles when a selected operation completes. The code chooses which completions are selected: program completions, block-erase completions, or both.

All outputs are registered. Every input decision reaches the outputs on the next rising clock edge.

Top module: `sts_pin_ctrl`

## Requirements
- R1: A cycle with `rst` high sets `mode` to 2'b00 (level mode) at that clock edge.
- R2: On each cycle with `rst` high, after that clock edge `pin_pd_n` is 0 only if `pec_busy`=1 and `pec_suspended`=0 were sampled. Otherwise it is 1 (released).
- R3: In level mode (`mode`=00), after each edge `pin_pd_n` = !(`pec_busy` && !`pec_suspended`) of the sampled inputs. Entering suspend therefore releases the pin on the next edge, and resuming pulls it low on the next edge.
- R4: In a pulse mode, a selected completion event sampled at an edge makes `pin_pd_n` 0 for exactly `PULSE_LEN` cycles (default 4), starting after that edge. The pin is released after those cycles.
- R5: The mode code selects the completion events that start a pulse. Code 01 selects `prog_done` only, code 10 selects `erase_done` only, and code 11 selects either one. A completion event that the code does not select leaves the pin released.
- R6: A selected event that arrives during a pulse restarts the count. The pin then stays low for `PULSE_LEN` cycles after that event.
- R7: `mode` changes only on a cycle with `cfg_valid`=1. After that edge, `mode` equals the sampled `cfg_code`.
- R8: A configure strobe cancels any pulse in progress. After the strobe's edge, the pin is released if the new code is a pulse mode. It follows R3 for the sampled busy and suspend inputs if the new code is 00. Completion events in the strobe cycle are ignored.
- R9: In a pulse mode, `pec_busy` and `pec_suspended` have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configure strobe, one cycle |
| cfg_code | input | 2 | Mode code: 00 level, 01 program pulse, 10 erase pulse, 11 either |
| pec_busy | input | 1 | Program/erase controller running an operation |
| pec_suspended | input | 1 | Running operation is suspended |
| prog_done | input | 1 | One-cycle program completion event |
| erase_done | input | 1 | One-cycle block-erase completion event |
| pin_pd_n | output | 1 | Pull-down enable, 0 pulls the pin low, 1 releases it |
| mode | output | 2 | Current mode code |

## Verification
The checker watches every cycle for the following:
- the reset values of the mode and the pin;
- the level-mode mapping from busy and suspend to the pin;
- the start of a pulse on a selected event;
- a released pin staying released when no selected event arrives, which covers unselected events and busy activity in pulse modes;
- the mode holding or loading;
- the cancellation of a pulse by a configure strobe.

Only the bench scenarios show the following. They do so by comparing against a cycle model over directed and random sequences:
- the exact pulse length;
- the end of the pulse;
- the restart of the count by a retrigger.

// File: rtl/sts_pkg.sv
package sts_pkg;
  typedef enum logic [1:0] {
    MODE_LEVEL = 2'b00,
    MODE_PROG  = 2'b01,
    MODE_ERASE = 2'b10,
    MODE_ANY   = 2'b11
  } sts_mode_e;
endpackage

// File: rtl/sts_mode_reg.sv
module sts_mode_reg
  import sts_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_valid,
  input  logic [1:0] cfg_code,
  output sts_mode_e  mode_q,
  output sts_mode_e  mode_next
);
  always_comb begin
    if (rst)            mode_next = MODE_LEVEL;
    else if (cfg_valid) mode_next = sts_mode_e'(cfg_code);
    else                mode_next = mode_q;
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_next;
  end
endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic clk,
  input  logic clear,
  input  logic trigger,
  output logic active_next
);
  localparam int unsigned CW = $clog2(PULSE_LEN + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_n;

  always_comb begin
    if (clear)             cnt_n = '0;
    else if (trigger)      cnt_n = CW'(PULSE_LEN);
    else if (cnt_q != '0)  cnt_n = cnt_q - CW'(1);
    else                   cnt_n = cnt_q;
  end

  assign active_next = (cnt_n != '0);

  always_ff @(posedge clk) begin
    cnt_q <= cnt_n;
  end
endmodule

// File: rtl/sts_pin_drive.sv
module sts_pin_drive (
  input  logic clk,
  input  logic level_sel,
  input  logic busy_eff,
  input  logic pulse_active,
  output logic pin_pd_n
);
  logic pin_n;

  always_comb begin
    if (level_sel) pin_n = !busy_eff;
    else           pin_n = !pulse_active;
  end

  always_ff @(posedge clk) begin
    pin_pd_n <= pin_n;
  end
endmodule

// File: rtl/sts_pin_ctrl.sv
module sts_pin_ctrl
  import sts_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_valid,
  input  logic [1:0] cfg_code,
  input  logic       pec_busy,
  input  logic       pec_suspended,
  input  logic       prog_done,
  input  logic       erase_done,
  output logic       pin_pd_n,
  output logic [1:0] mode
);
  sts_mode_e mode_q;
  sts_mode_e mode_next;
  logic      sel_event;
  logic      timer_clear;
  logic      pulse_active;
  logic      busy_eff;

  sts_mode_reg u_mode (
    .clk       (clk),
    .rst       (rst),
    .cfg_valid (cfg_valid),
    .cfg_code  (cfg_code),
    .mode_q    (mode_q),
    .mode_next (mode_next)
  );

  assign sel_event   = !cfg_valid &&
                       ((mode_q[0] && prog_done) || (mode_q[1] && erase_done));
  assign timer_clear = rst || cfg_valid || (mode_q == MODE_LEVEL);
  assign busy_eff    = pec_busy && !pec_suspended;

  sts_pulse_timer #(.PULSE_LEN(PULSE_LEN)) u_timer (
    .clk         (clk),
    .clear       (timer_clear),
    .trigger     (sel_event),
    .active_next (pulse_active)
  );

  sts_pin_drive u_drive (
    .clk          (clk),
    .level_sel    (mode_next == MODE_LEVEL),
    .busy_eff     (busy_eff),
    .pulse_active (pulse_active),
    .pin_pd_n     (pin_pd_n)
  );

  assign mode = mode_q;
endmodule

// File: rtl/sts_pin_ctrl_chk.sv
module sts_pin_ctrl_chk #(
  parameter int unsigned PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       cfg_valid,
  input logic [1:0] cfg_code,
  input logic       pec_busy,
  input logic       pec_suspended,
  input logic       prog_done,
  input logic       erase_done,
  input logic       pin_pd_n,
  input logic [1:0] mode
);
  logic init_q = 1'b0;
  logic sel_ev;

  always_ff @(posedge clk) begin
    if (rst) init_q <= 1'b1;
  end

  assign sel_ev = (mode[0] && prog_done) || (mode[1] && erase_done);

  p_reset_mode_r1: assert property (@(posedge clk) disable iff (!init_q)
    rst |=> mode == 2'b00);

  p_reset_pin_r2: assert property (@(posedge clk) disable iff (!init_q)
    rst |=> pin_pd_n == !($past(pec_busy) && !$past(pec_suspended)));

  p_level_pin_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !cfg_valid) |=>
      pin_pd_n == !($past(pec_busy) && !$past(pec_suspended)));

  p_pulse_start_r4: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00 && !cfg_valid && sel_ev) |=> !pin_pd_n);

  p_quiet_release_r5: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b00 && !cfg_valid && pin_pd_n && !sel_ev) |=> pin_pd_n);

  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |=> $stable(mode));

  p_mode_load_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> mode == $past(cfg_code));

  p_cfg_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_code != 2'b00) |=> pin_pd_n);
endmodule

bind sts_pin_ctrl sts_pin_ctrl_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_valid     (cfg_valid),
  .cfg_code      (cfg_code),
  .pec_busy      (pec_busy),
  .pec_suspended (pec_suspended),
  .prog_done     (prog_done),
  .erase_done    (erase_done),
  .pin_pd_n      (pin_pd_n),
  .mode          (mode)
);

// File: tb/sts_pin_ctrl_tb.sv
module sts_pin_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PLEN = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_valid = 1'b0;
  logic [1:0] cfg_code = 2'b00;
  logic       pec_busy = 1'b0;
  logic       pec_suspended = 1'b0;
  logic       prog_done = 1'b0;
  logic       erase_done = 1'b0;
  logic       pin_pd_n;
  logic [1:0] mode;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [1:0] exp_mode = 2'b00;
  int         exp_cnt = 0;
  logic       exp_pin = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sts_pin_ctrl #(.PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_code(cfg_code),
    .pec_busy(pec_busy), .pec_suspended(pec_suspended),
    .prog_done(prog_done), .erase_done(erase_done),
    .pin_pd_n(pin_pd_n), .mode(mode)
  );

  function automatic logic busy_pin(input logic b, input logic s);
    return !(b && !s);
  endfunction

  task automatic model_step();
    logic ev;
    if (rst) begin
      exp_mode = 2'b00; exp_cnt = 0;
      exp_pin = busy_pin(pec_busy, pec_suspended);
    end else if (cfg_valid) begin
      exp_mode = cfg_code; exp_cnt = 0;
      exp_pin = (cfg_code == 2'b00) ? busy_pin(pec_busy, pec_suspended) : 1'b1;
    end else if (exp_mode == 2'b00) begin
      exp_cnt = 0;
      exp_pin = busy_pin(pec_busy, pec_suspended);
    end else begin
      ev = (exp_mode[0] && prog_done) || (exp_mode[1] && erase_done);
      if (ev) exp_cnt = PLEN;
      else if (exp_cnt > 0) exp_cnt = exp_cnt - 1;
      exp_pin = (exp_cnt == 0);
    end
  endtask

  task automatic check(input string tag);
    n_checks++;
    if (pin_pd_n !== exp_pin || mode !== exp_mode) begin
      n_fail++;
      $display("FAIL %s: pin_pd_n=%b mode=%b expected pin_pd_n=%b mode=%b",
               tag, pin_pd_n, mode, exp_pin, exp_mode);
    end
  endtask

  task automatic cyc(input logic r, input logic cv, input logic [1:0] cc,
                     input logic b, input logic s, input logic p,
                     input logic e, input string tag);
    rst = r; cfg_valid = cv; cfg_code = cc;
    pec_busy = b; pec_suspended = s; prog_done = p; erase_done = e;
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    @(negedge clk);
    cyc(1, 0, 2'b00, 0, 0, 0, 0, "R1 reset idle");
    cyc(1, 0, 2'b00, 1, 0, 0, 0, "R2 reset while busy");
    cyc(1, 0, 2'b00, 1, 1, 0, 0, "R2 reset while suspended");
    cyc(0, 0, 2'b00, 1, 0, 0, 0, "R3 busy low");
    cyc(0, 0, 2'b00, 1, 1, 0, 0, "R3 suspend releases");
    cyc(0, 0, 2'b00, 1, 0, 0, 0, "R3 resume pulls low");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R3 idle released");
    cyc(0, 1, 2'b01, 1, 0, 0, 0, "R7 load program mode");
    cyc(0, 0, 2'b00, 1, 0, 0, 0, "R9 busy ignored");
    cyc(0, 0, 2'b00, 0, 0, 0, 1, "R5 erase unselected");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R4 program pulse start");
    for (int i = 0; i < PLEN; i++) cyc(0, 0, 2'b00, 1, 0, 0, 0, "R4 pulse run");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R6 first event");
    cyc(0, 0, 2'b00, 0, 0, 0, 0, "R6 running");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R6 retrigger");
    for (int i = 0; i < PLEN; i++) cyc(0, 0, 2'b00, 0, 0, 0, 0, "R6 after retrigger");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R8 pulse before cancel");
    cyc(0, 1, 2'b10, 0, 0, 1, 1, "R8 cancel by strobe");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R5 program unselected");
    cyc(0, 0, 2'b00, 0, 0, 0, 1, "R5 erase pulse");
    cyc(0, 1, 2'b11, 0, 0, 0, 0, "R7 load either mode");
    cyc(0, 0, 2'b00, 0, 0, 0, 1, "R5 either erase");
    for (int i = 0; i < PLEN; i++) cyc(0, 0, 2'b00, 0, 0, 0, 0, "R4 either drain");
    cyc(0, 0, 2'b00, 0, 0, 1, 0, "R5 either program");
    cyc(0, 1, 2'b00, 1, 0, 0, 0, "R8 back to level while busy");
    cyc(0, 0, 2'b01, 1, 0, 0, 0, "R7 code without strobe");
    cyc(0, 1, 2'b10, 0, 0, 0, 1, "R8 pulse mode via strobe");
    cyc(0, 0, 2'b00, 0, 0, 0, 1, "R4 pulse again");
    cyc(1, 0, 2'b00, 0, 0, 0, 0, "R1 reset in pulse mode");
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic r, cv, b, s, p, e;
      logic [1:0] cc;
      string tag;
      r  = ($urandom % 100) < 2;
      cv = ($urandom % 100) < 5;
      cc = 2'($urandom);
      b  = ($urandom % 100) < 60;
      s  = ($urandom % 100) < 20;
      p  = ($urandom % 100) < 15;
      e  = ($urandom % 100) < 15;
      if (r) tag = "R2 random reset";
      else if (cv) tag = "R8 random strobe";
      else if (exp_mode == 2'b00) tag = "R3 random level";
      else tag = "R4 random pulse";
      cyc(r, cv, cc, b, s, p, e, tag);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule